// File: doc/BRIEF.md
# Expansion ROM Read Timing Controller

This block fetches single bytes from an external parallel flash or EPROM for an on-chip requester. A request supplies a 20-bit byte address. The block puts that address on the external pins and pulls chip enable and output enable low. It then waits a programmable number of slow ROM-clock periods and latches the byte on a ROM-clock edge. The ROM clock is an internal tick at one quarter of the core clock. After the byte is latched, the strobes stay low for one more ROM-clock period, then the block goes idle again.

The hold length comes from a 4-bit timing field. It is reachable through two write views: a narrow timing view, and a wider control word in which the field sits at bits 11:8. Both read views always agree. Size the field as one plus the device access time divided by the ROM-clock period. The extra period covers the address output delay plus the data setup time. A zero is never stored.

Requests use a valid/ready handshake. Ready is high only while the block is idle, so a request presented during an access waits, and has no effect, until ready returns. The response is a one-cycle valid pulse with no ready. The requester must accept it in the cycle it appears.

Top module: `xrom_rd_ctrl`

## Requirements
- R1: The ROM clock is a tick every fourth core clock. Its phase restarts with each accepted request, so the first ROM-clock edge of an access falls on the fourth core edge after the accepting edge.
- R2: With timing value N, the response valid rises exactly 4*N core cycles after the edge that accepted the request. The external address equals the request address and does not change during that time.
- R3: The response data equals the byte on the external data pins at the ROM-clock edge that ends the hold window.
- R4: Hard reset sets the timing field to 4'b1001 and the control word to 16'h0900. It leaves the block idle with ready high, both strobes high and no response.
- R5: Writing zero to the timing field through either view stores 1.
- R6: The timing view writes write_data[3:0]. The control view (write_ctl=1) writes the whole 16-bit word, and its bits 11:8 are the timing field. A write through either view is visible in both read views.
- R7: Soft reset aborts any access: strobes go high, ready goes high and no response follows. It clears the control word outside bits 11:8 and leaves the timing field unchanged.
- R8: Chip enable and output enable are low from the accepting edge until 4 core cycles after the capture. They are high whenever the block is idle.
- R9: The response valid is a single-cycle pulse, once per completed access.
- R10: A request raised while ready is low is not taken. The external address does not change, and no extra response appears.
- R11: The hold length is fixed when a request is accepted. Timing writes during an access apply from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | High when idle and able to take a request |
| req_addr | input | 20 | Byte address of the request |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_data | output | 8 | Byte read from the ROM |
| write_en | input | 1 | Timing/control register write strobe |
| write_ctl | input | 1 | 0: timing view, 1: control-word view |
| write_data | input | 16 | Register write data |
| tmg_q | output | 4 | Timing field read view |
| ctl_q | output | 16 | Control word read view |
| rom_addr | output | 20 | External address pins |
| rom_data | input | 8 | External data pins |
| rom_ce_n | output | 1 | External chip enable, active low |
| rom_oe_n | output | 1 | External output enable, active low |

## Verification
The bench builds the block with its default parameters: a 20-bit address, 8-bit data, a divide ratio of four and a 4-bit timing field at bits 11:8 of a 16-bit control word. This width makes every legal hold value from 1 to 15 reachable, so the bench sweeps all of them and measures the exact 4*N response delay. It also reaches the reset value 9 and the zero-to-one clamp. Its ROM model returns a byte computed from the address, so a capture from the wrong address or at the wrong edge shows up in the data.

// File: rtl/xrom_pkg.sv
package xrom_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_HOLD  = 2'd1,
    XS_RECOV = 2'd2
  } xrom_state_e;

  typedef enum logic {
    WV_TMG = 1'b0,
    WV_CTL = 1'b1
  } xrom_view_e;

endpackage

// File: rtl/xrom_phase_div.sv
module xrom_phase_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ph_q <= '0;
    else if (!run)        ph_q <= '0;
    else if (ph_q == LAST) ph_q <= '0;
    else                  ph_q <= ph_q + 1'b1;
  end

  assign tick = run && (ph_q == LAST);
endmodule

// File: rtl/xrom_tmg_regs.sv
module xrom_tmg_regs
  import xrom_pkg::*;
#(
  parameter int TMG_W   = 4,
  parameter int CTL_W   = 16,
  parameter int TMG_LSB = 8,
  parameter int TMG_RST = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic             wr_ctl,
  input  logic [CTL_W-1:0] wr_data,
  output logic [TMG_W-1:0] tmg_q,
  output logic [CTL_W-1:0] ctl_q
);
  localparam logic [CTL_W-1:0] SLOT = CTL_W'(((1 << TMG_W) - 1) << TMG_LSB);

  xrom_view_e       view;
  logic [TMG_W-1:0] field_raw, field_new, tmg_r;
  logic [CTL_W-1:0] rest_r;

  assign view = xrom_view_e'(wr_ctl);

  always_comb begin
    if (view == WV_CTL) field_raw = wr_data[TMG_LSB +: TMG_W];
    else                field_raw = wr_data[TMG_W-1:0];
    field_new = (field_raw == '0) ? TMG_W'(1) : field_raw;
  end

  // timing field: hard reset only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tmg_r <= TMG_W'(TMG_RST);
    else if (wr_en) tmg_r <= field_new;
  end

  // remaining control bits: cleared by soft reset too
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         rest_r <= '0;
    else if (soft_rst)                  rest_r <= '0;
    else if (wr_en && view == WV_CTL)   rest_r <= wr_data & ~SLOT;
  end

  assign tmg_q = tmg_r;
  assign ctl_q = rest_r | (CTL_W'(tmg_r) << TMG_LSB);
endmodule

// File: rtl/xrom_access_fsm.sv
module xrom_access_fsm
  import xrom_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int TMG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              tick,
  input  logic [TMG_W-1:0]  tmg_val,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              run,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  input  logic [DATA_W-1:0] rom_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  xrom_state_e       state_q;
  logic [TMG_W-1:0]  hold_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              sel_n_q, rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      hold_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      sel_n_q <= 1'b1;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      if (soft_rst) begin
        state_q <= XS_IDLE;
        sel_n_q <= 1'b1;
      end else begin
        case (state_q)
          XS_IDLE: if (req_valid) begin
            addr_q  <= req_addr;
            hold_q  <= (tmg_val == '0) ? TMG_W'(1) : tmg_val;
            sel_n_q <= 1'b0;
            state_q <= XS_HOLD;
          end
          XS_HOLD: if (tick) begin
            if (hold_q == TMG_W'(1)) begin
              data_q  <= rom_data;
              rsp_q   <= 1'b1;
              state_q <= XS_RECOV;
            end else begin
              hold_q <= hold_q - 1'b1;
            end
          end
          XS_RECOV: if (tick) begin
            sel_n_q <= 1'b1;
            state_q <= XS_IDLE;
          end
          default: state_q <= XS_IDLE;
        endcase
      end
    end
  end

  assign req_ready = (state_q == XS_IDLE);
  assign run       = (state_q != XS_IDLE);
  assign rom_addr  = addr_q;
  assign rom_ce_n  = sel_n_q;
  assign rom_oe_n  = sel_n_q;
  assign rsp_valid = rsp_q;
  assign rsp_data  = data_q;
endmodule

// File: rtl/xrom_rd_ctrl.sv
module xrom_rd_ctrl #(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 8,
  parameter int DIV     = 4,
  parameter int TMG_W   = 4,
  parameter int CTL_W   = 16,
  parameter int TMG_LSB = 8,
  parameter int TMG_RST = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              write_en,
  input  logic              write_ctl,
  input  logic [CTL_W-1:0]  write_data,
  output logic [TMG_W-1:0]  tmg_q,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic              rom_ce_n,
  output logic              rom_oe_n
);
  logic tick, run;

  xrom_phase_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  xrom_tmg_regs #(
    .TMG_W(TMG_W), .CTL_W(CTL_W), .TMG_LSB(TMG_LSB), .TMG_RST(TMG_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(write_en), .wr_ctl(write_ctl), .wr_data(write_data),
    .tmg_q(tmg_q), .ctl_q(ctl_q)
  );

  xrom_access_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMG_W(TMG_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tick(tick),
    .tmg_val(tmg_q), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .run(run), .rom_addr(rom_addr),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_data(rom_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/xrom_rd_ctrl_chk.sv
module xrom_rd_ctrl_chk #(
  parameter int ADDR_W  = 20,
  parameter int TMG_W   = 4,
  parameter int CTL_W   = 16,
  parameter int TMG_LSB = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              write_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              rom_ce_n,
  input logic              rom_oe_n,
  input logic              rsp_valid,
  input logic [TMG_W-1:0]  tmg_q,
  input logic [CTL_W-1:0]  ctl_q
);
  localparam logic [CTL_W-1:0] SLOT = CTL_W'(((1 << TMG_W) - 1) << TMG_LSB);

  AST_TMG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tmg_q != '0);  // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(rom_addr));  // R2
  AST_SELECT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (!rom_ce_n && !rom_oe_n));  // R8
  AST_SELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rom_ce_n && rom_oe_n));  // R8
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);  // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(rom_addr));  // R10
  AST_SOFT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !write_en) |=> (tmg_q == $past(tmg_q)));  // R7
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !write_en) |=> ((ctl_q & ~SLOT) == '0));  // R7
endmodule

bind xrom_rd_ctrl xrom_rd_ctrl_chk #(
  .ADDR_W(ADDR_W), .TMG_W(TMG_W), .CTL_W(CTL_W), .TMG_LSB(TMG_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .write_en(write_en),
  .req_valid(req_valid), .req_ready(req_ready), .rom_addr(rom_addr),
  .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rsp_valid(rsp_valid),
  .tmg_q(tmg_q), .ctl_q(ctl_q)
);

// File: tb/xrom_rd_ctrl_test.sv
`timescale 1ns/1ps
module xrom_rd_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        write_en = 1'b0;
  logic        write_ctl = 1'b0;
  logic [15:0] write_data = '0;
  logic [3:0]  tmg_q;
  logic [15:0] ctl_q;
  logic [19:0] rom_addr;
  logic [7:0]  rom_data;
  logic        rom_ce_n, rom_oe_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rom_model(input logic [19:0] a);
    return a[7:0] ^ a[19:12] ^ 8'h5A;
  endfunction
  assign rom_data = rom_model(rom_addr);

  xrom_rd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .write_en(write_en), .write_ctl(write_ctl), .write_data(write_data),
    .tmg_q(tmg_q), .ctl_q(ctl_q),
    .rom_addr(rom_addr), .rom_data(rom_data),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input bit ctl_view, input logic [15:0] d);
    @(negedge clk);
    write_en = 1'b1; write_ctl = ctl_view; write_data = d;
    @(posedge clk);
    @(negedge clk);
    write_en = 1'b0;
  endtask

  // poke: 0 none, 1 second request mid-access, 2 timing write mid-access
  task automatic do_access(input logic [19:0] a, input int n, input int poke,
                           input logic [3:0] newt);
    int cyc;
    bit bad_addr, bad_sel, bad_ready;
    cyc = 0; bad_addr = 0; bad_sel = 0; bad_ready = 0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R8", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && cyc < 100) begin
      if (rom_addr !== a) bad_addr = 1;
      if (rom_ce_n !== 1'b0 || rom_oe_n !== 1'b0) bad_sel = 1;
      if (req_ready !== 1'b0) bad_ready = 1;
      if (poke == 1 && cyc == 2) begin req_valid = 1'b1; req_addr = ~a; end
      if (poke == 2 && cyc == 2) begin
        write_en = 1'b1; write_ctl = 1'b0; write_data = {12'h000, newt};
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; write_en = 1'b0;
      cyc++;
    end
    chk(cyc == 4 * n, "R1 R2", "cycles to response", cyc, 4 * n);
    chk(!bad_addr && rom_addr === a, "R2", "address held", rom_addr, a);
    chk(!bad_sel, "R8", "strobes low in window", bad_sel, 0);
    chk(!bad_ready, "R10", "ready low in window", bad_ready, 0);
    chk(rsp_data === rom_model(a), "R3", "captured byte", rsp_data, rom_model(a));
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 1) chk(rsp_valid === 1'b0, "R9", "single pulse", rsp_valid, 0);
      if (k < 4)
        chk(rom_ce_n === 1'b0 && req_ready === 1'b0, "R8",
            "strobe in recovery", rom_ce_n, 0);
      else
        chk(rom_ce_n === 1'b1 && rom_oe_n === 1'b1 && req_ready === 1'b1,
            "R8", "strobes released", {rom_ce_n, rom_oe_n, req_ready}, 3'b111);
    end
    if (poke == 1) begin
      repeat (8) begin
        @(negedge clk);
        if (rsp_valid !== 1'b0 || rom_addr !== a) bad_addr = 1;
      end
      chk(!bad_addr, "R10", "busy request ignored", rom_addr, a);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(tmg_q === 4'b1001, "R4", "timing reset", tmg_q, 9);
    chk(ctl_q === 16'h0900, "R4", "control reset", ctl_q, 16'h0900);
    chk(req_ready === 1'b1 && rom_ce_n === 1'b1 && rom_oe_n === 1'b1 &&
        rsp_valid === 1'b0, "R4", "idle outputs",
        {req_ready, rom_ce_n, rom_oe_n, rsp_valid}, 4'b1110);
    do_access(20'hABCDE, 9, 0, 4'h0);
  endtask

  task automatic t_sweep;
    for (int n = 1; n <= 15; n++) begin
      reg_write(1'b0, 16'(n));
      chk(tmg_q === 4'(n), "R6", "timing view write", tmg_q, n);
      do_access(20'(n * 20'h1111 + 20'h00307), n, 0, 4'h0);
    end
  endtask

  task automatic t_zero_alias;
    reg_write(1'b0, 16'h0000);
    chk(tmg_q === 4'h1, "R5", "zero via timing view", tmg_q, 1);
    chk(ctl_q === 16'h0100, "R5", "zero view in control", ctl_q, 16'h0100);
    do_access(20'h00042, 1, 0, 4'h0);
    reg_write(1'b1, 16'h0012);
    chk(ctl_q === 16'h0112, "R5", "zero via control view", ctl_q, 16'h0112);
    reg_write(1'b1, 16'h0B00);
    chk(tmg_q === 4'hB, "R6", "control write to timing", tmg_q, 4'hB);
    reg_write(1'b0, 16'h0007);
    chk(ctl_q === 16'h0700, "R6", "timing write to control", ctl_q, 16'h0700);
  endtask

  task automatic t_busy_and_midwrite;
    reg_write(1'b0, 16'h0003);
    do_access(20'h5A5A5, 3, 1, 4'h0);
    do_access(20'h12345, 3, 2, 4'h6);
    chk(tmg_q === 4'h6, "R11", "mid-access write stored", tmg_q, 6);
    do_access(20'h0F0F0, 6, 0, 4'h0);  // R11 new value on next request
  endtask

  task automatic t_soft;
    bit seen;
    seen = 0;
    reg_write(1'b1, 16'hA35C);
    chk(ctl_q === 16'hA35C && tmg_q === 4'h3, "R6", "full control write",
        ctl_q, 16'hA35C);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 20'h77777;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(rom_ce_n === 1'b1 && req_ready === 1'b1, "R7", "access aborted",
        {rom_ce_n, req_ready}, 2'b11);
    chk(tmg_q === 4'h3, "R7", "timing kept", tmg_q, 3);
    chk(ctl_q === 16'h0300, "R7", "other bits cleared", ctl_q, 16'h0300);
    repeat (20) begin
      @(negedge clk);
      if (rsp_valid !== 1'b0) seen = 1;
    end
    chk(!seen, "R7", "no response after abort", seen, 0);
    do_access(20'h00001, 3, 0, 4'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sweep();
    t_zero_alias();
    t_busy_and_midwrite();
    t_soft();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule